// File: doc/BRIEF.md
# CHS to Linear Block Address Translator

This block turns a cylinder/head/sector disk address into a zero-based linear block number, using a drive geometry the host has programmed. The geometry gives the number of heads minus one and the number of sectors on each track. Sectors are numbered from 1, so linear block 0 is cylinder 0, head 0, sector 1. In CHS mode the block number is computed as ((cylinder × heads) + head) × sectors_per_track + (sector − 1). The product is built by a sequential shift-and-add unit over two passes, one per factor, so the block needs no wide multiplier.

The same block holds the current address of a command in progress. Each time a sector has been transferred, an advance strobe moves the address on. In CHS mode the sector, head and cylinder fields wrap against the geometry captured at start. In LBA mode the 28-bit number simply counts up and is split back into the register fields. At command end the fields therefore show the address that the task-file registers must report. An address whose head or sector does not fit the geometry is rejected with an out-of-range flag.

Top module: `chs_lba_xlat`

## Requirements
- R1: While `rst` is high and in the cycle after it, `busy`, `done`, `range_err`, `lba_out`, `cur_cyl`, `cur_head` and `cur_sect` are all zero.
- R2: A CHS start with head ≤ `geo_heads_m1` and 1 ≤ sector ≤ `geo_spt` yields `lba_out` = ((cyl × (geo_heads_m1+1)) + head) × geo_spt + sector − 1, and `cur_cyl`/`cur_head`/`cur_sect` equal the inputs.
- R3: A valid CHS conversion holds `busy` high and raises `done` exactly 18 cycles (2 × 8 multiplier bits + 2) after the clock edge that accepts `start`. A `start` seen while `busy` is high is ignored.
- R4: An LBA start (`lba_mode`=1) copies `lba_in` to `lba_out` and raises `done` right after the accepting edge. It splits the address so that `cur_sect` = bits 7..0, `cur_cyl` = bits 23..8 (low byte 15..8, high byte 23..16) and `cur_head` = bits 27..24.
- R5: A CHS start with sector 0, sector > `geo_spt` or head > `geo_heads_m1` raises `done` right after the accepting edge with `range_err`=1 and `lba_out`=0. The flag stays high until the next accepted start.
- R6: In CHS mode an advance increments the sector. If the sector equalled sectors_per_track, it becomes 1 and the head increments. If the head also equalled heads−1, the head becomes 0 and the cylinder increments modulo 2^16. `lba_out` also increments. All of this shows the cycle after the strobe.
- R7: In LBA mode an advance increments `lba_out` modulo 2^28 and re-splits it into the fields as in R4.
- R8: An advance has no effect while `busy`, after a range error, before the first successful conversion after reset, or when `start` is accepted in the same cycle (start wins).
- R9: Geometry is captured when `start` is accepted. Later changes on `geo_heads_m1`/`geo_spt` do not alter the wrapping of advances.
- R10: `done` is high only while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a conversion or load of the inputs |
| advance | input | 1 | Step the current address by one sector |
| lba_mode | input | 1 | 1: address given as linear block number; 0: CHS |
| cyl_in | input | 16 | Cylinder for CHS start |
| head_in | input | 4 | Head for CHS start |
| sect_in | input | 8 | Sector (1-based) for CHS start |
| lba_in | input | 28 | Linear block number for LBA start |
| geo_heads_m1 | input | 4 | Heads per cylinder minus one |
| geo_spt | input | 8 | Sectors per track |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle result-valid pulse |
| range_err | output | 1 | Last CHS start was outside the geometry |
| lba_out | output | 28 | Current linear block number |
| cur_cyl | output | 16 | Current cylinder field |
| cur_head | output | 4 | Current head field |
| cur_sect | output | 8 | Current sector field |

## Verification
The start of a new conversion and the advance of the held address can both be requested on one edge. The bench provokes this by raising `start` and `advance` together after a valid result, in both modes. It judges the outcome by requiring that the outputs show the freshly loaded address and not the old one plus one. It also drives `start` and `advance` in the middle of a busy CHS conversion, and it expects the original result and fields once `done` arrives.

// File: rtl/chs_lba_pkg.sv
package chs_lba_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_MUL_H = 3'd1,
    ST_LOAD2 = 3'd2,
    ST_MUL_S = 3'd3,
    ST_FIN   = 3'd4
  } xlat_state_t;

endpackage

// File: rtl/chs_range_chk.sv
module chs_range_chk #(
  parameter int HEAD_W = 4,
  parameter int SECT_W = 8
) (
  input  logic [HEAD_W-1:0] head,
  input  logic [SECT_W-1:0] sect,
  input  logic [HEAD_W-1:0] heads_m1,
  input  logic [SECT_W-1:0] spt,
  output logic              bad
);

  logic sect_zero;
  logic sect_high;
  logic head_high;

  always_comb begin
    sect_zero = (sect == '0);
    sect_high = (sect > spt);
    head_high = (head > heads_m1);
    bad       = sect_zero | sect_high | head_high;
  end

endmodule

// File: rtl/chs_addr_step.sv
module chs_addr_step #(
  parameter int CYL_W  = 16,
  parameter int HEAD_W = 4,
  parameter int SECT_W = 8
) (
  input  logic [CYL_W-1:0]  cyl,
  input  logic [HEAD_W-1:0] head,
  input  logic [SECT_W-1:0] sect,
  input  logic [HEAD_W-1:0] heads_m1,
  input  logic [SECT_W-1:0] spt,
  output logic [CYL_W-1:0]  cyl_nx,
  output logic [HEAD_W-1:0] head_nx,
  output logic [SECT_W-1:0] sect_nx
);

  logic track_end;
  logic cyl_end;

  always_comb begin
    track_end = (sect == spt);
    cyl_end   = track_end && (head == heads_m1);
    cyl_nx    = cyl;
    head_nx   = head;
    sect_nx   = sect + SECT_W'(1);
    if (track_end) begin
      sect_nx = SECT_W'(1);
      head_nx = head + HEAD_W'(1);
    end
    if (cyl_end) begin
      head_nx = '0;
      cyl_nx  = cyl + CYL_W'(1);
    end
  end

endmodule

// File: rtl/chs_shift_mac.sv
module chs_shift_mac #(
  parameter int ACC_W = 28,
  parameter int MUL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic [ACC_W-1:0] mcand_in,
  input  logic [MUL_W-1:0] mplier_in,
  input  logic [ACC_W-1:0] addend_in,
  output logic [ACC_W-1:0] acc,
  output logic             last
);

  localparam int CNT_W = (MUL_W > 1) ? $clog2(MUL_W) : 1;

  logic [ACC_W-1:0] mcand_q;
  logic [MUL_W-1:0] mplier_q;
  logic [CNT_W-1:0] cnt_q;

  assign last = step && (cnt_q == CNT_W'(MUL_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      cnt_q    <= '0;
    end else if (load) begin
      acc      <= addend_in;
      mcand_q  <= mcand_in;
      mplier_q <= mplier_in;
      cnt_q    <= '0;
    end else if (step) begin
      if (mplier_q[0]) begin
        acc <= acc + mcand_q;
      end
      mcand_q  <= mcand_q << 1;
      mplier_q <= mplier_q >> 1;
      cnt_q    <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/chs_lba_xlat.sv
module chs_lba_xlat #(
  parameter int CYL_W  = 16,
  parameter int HEAD_W = 4,
  parameter int SECT_W = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            start,
  input  logic                            advance,
  input  logic                            lba_mode,
  input  logic [CYL_W-1:0]                cyl_in,
  input  logic [HEAD_W-1:0]               head_in,
  input  logic [SECT_W-1:0]               sect_in,
  input  logic [CYL_W+HEAD_W+SECT_W-1:0]  lba_in,
  input  logic [HEAD_W-1:0]               geo_heads_m1,
  input  logic [SECT_W-1:0]               geo_spt,
  output logic                            busy,
  output logic                            done,
  output logic                            range_err,
  output logic [CYL_W+HEAD_W+SECT_W-1:0]  lba_out,
  output logic [CYL_W-1:0]                cur_cyl,
  output logic [HEAD_W-1:0]               cur_head,
  output logic [SECT_W-1:0]               cur_sect
);
  import chs_lba_pkg::*;

  localparam int LBA_W = CYL_W + HEAD_W + SECT_W;
  localparam int MUL_W = (HEAD_W + 1 > SECT_W) ? HEAD_W + 1 : SECT_W;

  xlat_state_t       state_q;
  logic              mode_q;
  logic              valid_q;
  logic [HEAD_W-1:0] hm1_q;
  logic [SECT_W-1:0] spt_q;

  logic              in_bad;
  logic              idle;
  logic              accept;
  logic              adv_ok;
  logic [CYL_W-1:0]  cyl_nx;
  logic [HEAD_W-1:0] head_nx;
  logic [SECT_W-1:0] sect_nx;
  logic [LBA_W-1:0]  lba_inc;

  logic              mac_load;
  logic              mac_step;
  logic [LBA_W-1:0]  mac_mcand;
  logic [MUL_W-1:0]  mac_mplier;
  logic [LBA_W-1:0]  mac_addend;
  logic [LBA_W-1:0]  mac_acc;
  logic              mac_last;

  chs_range_chk #(.HEAD_W(HEAD_W), .SECT_W(SECT_W)) u_range (
    .head     (head_in),
    .sect     (sect_in),
    .heads_m1 (geo_heads_m1),
    .spt      (geo_spt),
    .bad      (in_bad)
  );

  chs_addr_step #(.CYL_W(CYL_W), .HEAD_W(HEAD_W), .SECT_W(SECT_W)) u_step (
    .cyl      (cur_cyl),
    .head     (cur_head),
    .sect     (cur_sect),
    .heads_m1 (hm1_q),
    .spt      (spt_q),
    .cyl_nx   (cyl_nx),
    .head_nx  (head_nx),
    .sect_nx  (sect_nx)
  );

  chs_shift_mac #(.ACC_W(LBA_W), .MUL_W(MUL_W)) u_mac (
    .clk       (clk),
    .rst       (rst),
    .load      (mac_load),
    .step      (mac_step),
    .mcand_in  (mac_mcand),
    .mplier_in (mac_mplier),
    .addend_in (mac_addend),
    .acc       (mac_acc),
    .last      (mac_last)
  );

  always_comb begin
    idle    = (state_q == ST_IDLE);
    busy    = !idle;
    accept  = idle && start;
    adv_ok  = idle && !start && advance && valid_q;
    lba_inc = lba_out + LBA_W'(1);

    mac_step   = (state_q == ST_MUL_H) || (state_q == ST_MUL_S);
    mac_load   = (accept && !lba_mode && !in_bad) || (state_q == ST_LOAD2);
    mac_mcand  = LBA_W'(cyl_in);
    mac_mplier = MUL_W'(geo_heads_m1) + MUL_W'(1);
    mac_addend = LBA_W'(head_in);
    if (state_q == ST_LOAD2) begin
      mac_mcand  = mac_acc;
      mac_mplier = MUL_W'(spt_q);
      mac_addend = LBA_W'(cur_sect - SECT_W'(1));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      mode_q    <= 1'b0;
      valid_q   <= 1'b0;
      hm1_q     <= '0;
      spt_q     <= '0;
      done      <= 1'b0;
      range_err <= 1'b0;
      lba_out   <= '0;
      cur_cyl   <= '0;
      cur_head  <= '0;
      cur_sect  <= '0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            mode_q <= lba_mode;
            hm1_q  <= geo_heads_m1;
            spt_q  <= geo_spt;
            if (lba_mode) begin
              {cur_head, cur_cyl, cur_sect} <= lba_in;
              lba_out   <= lba_in;
              range_err <= 1'b0;
              valid_q   <= 1'b1;
              done      <= 1'b1;
            end else begin
              cur_cyl  <= cyl_in;
              cur_head <= head_in;
              cur_sect <= sect_in;
              valid_q  <= 1'b0;
              if (in_bad) begin
                range_err <= 1'b1;
                lba_out   <= '0;
                done      <= 1'b1;
              end else begin
                range_err <= 1'b0;
                state_q   <= ST_MUL_H;
              end
            end
          end else if (adv_ok) begin
            lba_out <= lba_inc;
            if (mode_q) begin
              {cur_head, cur_cyl, cur_sect} <= lba_inc;
            end else begin
              cur_cyl  <= cyl_nx;
              cur_head <= head_nx;
              cur_sect <= sect_nx;
            end
          end
        end
        ST_MUL_H: begin
          if (mac_last) state_q <= ST_LOAD2;
        end
        ST_LOAD2: begin
          state_q <= ST_MUL_S;
        end
        ST_MUL_S: begin
          if (mac_last) state_q <= ST_FIN;
        end
        ST_FIN: begin
          lba_out <= mac_acc;
          valid_q <= 1'b1;
          done    <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/chs_lba_xlat_chk.sv
module chs_lba_xlat_chk #(
  parameter int CYL_W  = 16,
  parameter int HEAD_W = 4,
  parameter int SECT_W = 8
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           start,
  input logic                           advance,
  input logic                           busy,
  input logic                           done,
  input logic                           range_err,
  input logic [CYL_W+HEAD_W+SECT_W-1:0] lba_out,
  input logic [CYL_W-1:0]               cur_cyl,
  input logic [HEAD_W-1:0]              cur_head,
  input logic [SECT_W-1:0]              cur_sect,
  input logic                           mode_q,
  input logic                           valid_q,
  input logic [SECT_W-1:0]              spt_q
);

  localparam int LBA_W = CYL_W + HEAD_W + SECT_W;

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy) else $error("done while busy"); // R10

  AST_SECT_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (done && !range_err && !mode_q) |-> (cur_sect != '0 && cur_sect <= spt_q))
    else $error("sector field outside geometry"); // R2

  AST_LBA_SPLIT: assert property (@(posedge clk) disable iff (rst)
    (done && mode_q) |-> ({cur_head, cur_cyl, cur_sect} == lba_out))
    else $error("fields do not match linear address"); // R4

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (range_err && !start) |=> (range_err && lba_out == '0))
    else $error("range error not held"); // R5

  AST_ADV_INC: assert property (@(posedge clk) disable iff (rst)
    (advance && !start && !busy && valid_q) |=> (lba_out == $past(lba_out) + LBA_W'(1)))
    else $error("advance did not add one"); // R6

  AST_BUSY_FIELDS: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(cur_cyl) && $stable(cur_head) && $stable(cur_sect)))
    else $error("fields moved while busy"); // R8

endmodule

bind chs_lba_xlat chs_lba_xlat_chk #(
  .CYL_W(CYL_W), .HEAD_W(HEAD_W), .SECT_W(SECT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .advance   (advance),
  .busy      (busy),
  .done      (done),
  .range_err (range_err),
  .lba_out   (lba_out),
  .cur_cyl   (cur_cyl),
  .cur_head  (cur_head),
  .cur_sect  (cur_sect),
  .mode_q    (mode_q),
  .valid_q   (valid_q),
  .spt_q     (spt_q)
);

// File: tb/chs_lba_xlat_test.sv
`timescale 1ns/1ps
module chs_lba_xlat_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        start, advance, lba_mode;
  logic [15:0] cyl_in;
  logic [3:0]  head_in;
  logic [7:0]  sect_in;
  logic [27:0] lba_in;
  logic [3:0]  geo_heads_m1;
  logic [7:0]  geo_spt;
  logic        busy, done, range_err;
  logic [27:0] lba_out;
  logic [15:0] cur_cyl;
  logic [3:0]  cur_head;
  logic [7:0]  cur_sect;

  int errors = 0;
  int checks = 0;

  logic [15:0] m_cyl;
  logic [3:0]  m_head, m_hm1;
  logic [7:0]  m_sect, m_spt;
  logic [27:0] m_lba;
  logic        m_mode;

  always #5 clk = ~clk;

  chs_lba_xlat uut (
    .clk(clk), .rst(rst), .start(start), .advance(advance), .lba_mode(lba_mode),
    .cyl_in(cyl_in), .head_in(head_in), .sect_in(sect_in), .lba_in(lba_in),
    .geo_heads_m1(geo_heads_m1), .geo_spt(geo_spt),
    .busy(busy), .done(done), .range_err(range_err), .lba_out(lba_out),
    .cur_cyl(cur_cyl), .cur_head(cur_head), .cur_sect(cur_sect)
  );

  function automatic logic [27:0] ref_lba(input logic [15:0] c, input logic [3:0] h,
                                          input logic [7:0] s, input logic [3:0] hm1,
                                          input logic [7:0] spt);
    longint v;
    v = ((longint'(c) * (longint'(hm1) + 1)) + longint'(h)) * longint'(spt)
        + longint'(s) - 1;
    return v[27:0];
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_fields(input string tag);
    chk({tag, " lba"},  lba_out,  m_lba);
    chk({tag, " cyl"},  cur_cyl,  m_cyl);
    chk({tag, " head"}, cur_head, m_head);
    chk({tag, " sect"}, cur_sect, m_sect);
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 60) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic run_chs(input logic [15:0] c, input logic [3:0] h, input logic [7:0] s,
                         input logic [3:0] hm1, input logic [7:0] spt);
    int n;
    lba_mode = 1'b0; cyl_in = c; head_in = h; sect_in = s;
    geo_heads_m1 = hm1; geo_spt = spt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(n);
    chk("R3 latency", n, 18);
    m_mode = 1'b0; m_cyl = c; m_head = h; m_sect = s; m_hm1 = hm1; m_spt = spt;
    m_lba = ref_lba(c, h, s, hm1, spt);
    chk("R2 range_err", range_err, 0);
    chk_fields("R2");
  endtask

  task automatic run_lba(input logic [27:0] l);
    int n;
    lba_mode = 1'b1; lba_in = l; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(n);
    chk("R4 latency", n, 0);
    m_mode = 1'b1; m_lba = l; m_sect = l[7:0]; m_cyl = l[23:8]; m_head = l[27:24];
    chk_fields("R4");
  endtask

  task automatic model_step();
    m_lba = m_lba + 28'd1;
    if (m_mode) begin
      m_sect = m_lba[7:0]; m_cyl = m_lba[23:8]; m_head = m_lba[27:24];
    end else if (m_sect == m_spt) begin
      m_sect = 8'd1;
      if (m_head == m_hm1) begin
        m_head = 4'd0;
        m_cyl  = m_cyl + 16'd1;
      end else begin
        m_head = m_head + 4'd1;
      end
    end else begin
      m_sect = m_sect + 8'd1;
    end
  endtask

  task automatic adv_once(input string tag);
    advance = 1'b1;
    @(negedge clk);
    advance = 1'b0;
    model_step();
    chk_fields(tag);
  endtask

  task automatic bad_chs(input logic [15:0] c, input logic [3:0] h, input logic [7:0] s,
                         input logic [3:0] hm1, input logic [7:0] spt, input string tag);
    int n;
    lba_mode = 1'b0; cyl_in = c; head_in = h; sect_in = s;
    geo_heads_m1 = hm1; geo_spt = spt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(n);
    chk({tag, " latency"}, n, 0);
    chk({tag, " flag"}, range_err, 1);
    chk({tag, " lba zero"}, lba_out, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed_sink;
    seed_sink = int'($urandom(32'h0000_5eed));
    rst = 1'b1; start = 1'b0; advance = 1'b0; lba_mode = 1'b0;
    cyl_in = '0; head_in = '0; sect_in = '0; lba_in = '0;
    geo_heads_m1 = '0; geo_spt = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 err", range_err, 0);
    chk("R1 lba", lba_out, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 cyl", cur_cyl, 0); chk("R1 head", cur_head, 0); chk("R1 sect", cur_sect, 0);
    // R8: advance before any conversion is ignored
    advance = 1'b1; @(negedge clk); advance = 1'b0;
    chk("R8 pre-convert lba", lba_out, 0);
    chk("R8 pre-convert sect", cur_sect, 0);

    // R2 directed: origin and largest address
    run_chs(16'd0, 4'd0, 8'd1, 4'd0, 8'd1);
    run_chs(16'hFFFF, 4'd15, 8'd255, 4'd15, 8'd255);
    // R6 full wrap: sector, head and cylinder all roll over
    adv_once("R6 cyl wrap");
    adv_once("R6 after wrap");
    run_chs(16'd7, 4'd2, 8'd17, 4'd2, 8'd17);
    adv_once("R6 head+cyl");
    run_chs(16'd3, 4'd0, 8'd9, 4'd4, 8'd9);
    adv_once("R6 head step");

    // R9: geometry changed after start does not alter wrapping
    run_chs(16'd5, 4'd1, 8'd2, 4'd1, 8'd2);
    geo_heads_m1 = 4'd15; geo_spt = 8'd255;
    adv_once("R9 captured geometry");

    // R5 range errors, then R8 advance ignored after error
    bad_chs(16'd1, 4'd0, 8'd0, 4'd3, 8'd10, "R5 sect zero");
    bad_chs(16'd1, 4'd0, 8'd11, 4'd3, 8'd10, "R5 sect high");
    bad_chs(16'd1, 4'd4, 8'd5, 4'd3, 8'd10, "R5 head high");
    advance = 1'b1; @(negedge clk); advance = 1'b0;
    chk("R8 after error lba", lba_out, 0);
    chk("R8 after error sect", cur_sect, 5);
    chk("R5 flag held", range_err, 1);

    // R7 LBA mode with wrap at the top of the range
    run_lba(28'hFFF_FFFE);
    chk("R5 flag cleared", range_err, 0);
    adv_once("R7 step");
    adv_once("R7 wrap");
    run_lba(28'h12_34FF);
    adv_once("R7 byte carry");

    // R8: start and advance in the same cycle, start wins
    lba_mode = 1'b1; lba_in = 28'h0AB_CDEF; start = 1'b1; advance = 1'b1;
    @(negedge clk);
    start = 1'b0; advance = 1'b0;
    chk("R8 start wins lba", lba_out, 28'h0AB_CDEF);
    chk("R8 start wins sect", cur_sect, 8'hEF);
    run_chs(16'd20, 4'd1, 8'd4, 4'd3, 8'd30);
    cyl_in = 16'd99; start = 1'b1; advance = 1'b1; lba_mode = 1'b0;
    @(negedge clk);
    start = 1'b0; advance = 1'b0;
    chk("R8 start wins busy", busy, 1);
    chk("R8 start wins cyl", cur_cyl, 99);

    // R3/R8: start and advance during a busy conversion are ignored
    begin
      int n;
      wait_done(n);
      m_cyl = 16'd99; m_head = 4'd1; m_sect = 8'd4; m_hm1 = 4'd3; m_spt = 8'd30;
      m_mode = 1'b0; m_lba = ref_lba(16'd99, 4'd1, 8'd4, 4'd3, 8'd30);
      chk_fields("R8 same-cycle result");
    end
    lba_mode = 1'b0; cyl_in = 16'd300; head_in = 4'd2; sect_in = 8'd6;
    geo_heads_m1 = 4'd5; geo_spt = 8'd40; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    lba_mode = 1'b1; lba_in = 28'h555_5555; start = 1'b1; advance = 1'b1;
    @(negedge clk);
    start = 1'b0; advance = 1'b0;
    begin
      int n;
      wait_done(n);
      chk("R3 busy ignore latency", n, 13);
    end
    m_mode = 1'b0; m_cyl = 16'd300; m_head = 4'd2; m_sect = 8'd6; m_hm1 = 4'd5; m_spt = 8'd40;
    m_lba = ref_lba(16'd300, 4'd2, 8'd6, 4'd5, 8'd40);
    chk_fields("R3 busy ignore");
    chk("R10 busy low at done", busy, 0);
    @(negedge clk);
    chk("R10 done pulse", done, 0);

    // Random CHS conversions with advances
    for (int i = 0; i < 40; i++) begin
      logic [3:0] hm1;
      logic [7:0] spt;
      int k;
      hm1 = 4'($urandom % 16);
      spt = 8'(1 + $urandom % 255);
      run_chs(16'($urandom), 4'($urandom % (int'(hm1) + 1)),
              8'(1 + $urandom % int'(spt)), hm1, spt);
      k = int'($urandom % 4);
      for (int j = 0; j < k; j++) adv_once("R6 random");
    end
    // Random LBA loads with advances
    for (int i = 0; i < 20; i++) begin
      run_lba(28'($urandom));
      adv_once("R7 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule